// File: doc/BRIEF.md
# Reversible Ripple-Carry Adder from Peres Primitives

This block adds two N-bit binary operands and a carry-in. It is built entirely from three-line reversible primitives, each of which maps (a, b, c) to (a, a XOR b, (a AND b) XOR c). Every bit position is one cell made of two such primitives in cascade. The first primitive is controlled by the operand bit x and acts on the incoming carry line and on a zero-initialised ancilla line. The second is controlled by y and acts on the two lines the first one produced. When the cell is done, the incoming carry line holds the sum bit and the ancilla holds the carry-out. That carry-out line becomes the carry-in line of the next position up.

The block has no clock and no state. All reversible lines come out at the top. The operands leave unchanged so that downstream logic can reuse them. The sum appears on the former carry lines, and the final carry on the last ancilla. The top level exposes its primitive count, Toffoli-equivalent count and cost tally as elaboration-time constants. Each primitive is counted at cost 4 and as two multiple-control Toffoli gates.

Top module: `peres_ripple_adder`

## Requirements
- R1: A primitive with inputs (a, b, c) produces outputs (a, a XOR b, (a AND b) XOR c).
- R2: A primitive is a bijection: its 8 input patterns give 8 distinct output patterns.
- R3: With every ancilla input at 0, {cout_o, sum_o} equals the integer x_i + y_i + cin_i for every input combination. A nonzero ancilla input is flagged by an assertion.
- R4: x_o equals x_i and y_o equals y_i for every input combination.
- R5: sum bit 0 equals x_i[0] XOR y_i[0] XOR cin_i, and sum bit k equals x_i[k] XOR y_i[k] XOR the carry out of position k-1.
- R6: The carry out of each position is the majority of that position's x, y and carry-in, and it feeds position k+1 in plain ripple order. All-ones x plus cin_i=1 ripples through every position to give sum 0 and cout 1.
- R7: The constants report 2N primitives, 4N Toffoli-equivalent gates, a cost of 8N and N ancilla lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | N | First operand lines |
| y_i | input | N | Second operand lines |
| cin_i | input | 1 | Carry-in line (becomes sum bit 0) |
| anc_i | input | N | Ancilla lines, must be 0 |
| x_o | output | N | First operand, passed through |
| y_o | output | N | Second operand, passed through |
| sum_o | output | N | Sum bits |
| cout_o | output | 1 | Final carry (last ancilla line) |

## Verification
The bench sweeps all 512 combinations of operands and carry-in at N=4. Each result is compared against integer addition, so a cell that swapped its control lines or took the carry from the wrong neighbour would produce wrong sums on some patterns. Operand pass-through is checked on every vector, because a primitive wired with its target on an operand line would corrupt x or y while still producing a plausible sum. The full-ripple case catches a carry chain that is broken or off by one position, which would otherwise only show up on long ripples. A standalone primitive is exercised over its 8 patterns for both mapping and bijectivity, which exposes an AND placed on the wrong output or a missing XOR.

// File: rtl/rev_adder_pkg.sv
package rev_adder_pkg;
  localparam int unsigned PRIM_COST   = 4;
  localparam int unsigned PRIM_MCT_EQ = 2;
  localparam int unsigned PRIMS_PER_CELL = 2;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/peres_gate.sv
module peres_gate (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic q_o,
  output logic r_o
);
  always_comb begin
    p_o = a_i;
    q_o = a_i ^ b_i;
    r_o = (a_i & b_i) ^ c_i;
  end
endmodule

// File: rtl/peres_add_cell.sv
module peres_add_cell
  import rev_adder_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic cin_i,
  input  logic anc_i,
  output logic x_o,
  output logic y_o,
  output logic sum_o,
  output logic cout_o
);
  logic mid_prop;
  logic mid_gen;

  peres_gate u_stage_x (
    .a_i(x_i), .b_i(cin_i), .c_i(anc_i),
    .p_o(x_o), .q_o(mid_prop), .r_o(mid_gen)
  );

  peres_gate u_stage_y (
    .a_i(y_i), .b_i(mid_prop), .c_i(mid_gen),
    .p_o(y_o), .q_o(sum_o), .r_o(cout_o)
  );

  always_comb begin
    AST_CELL_PASS: assert ((x_o == x_i) && (y_o == y_i)); // R4
    AST_CELL_SUM: assert (sum_o == (x_i ^ y_i ^ cin_i)); // R5
    if (anc_i == 1'b0) begin
      AST_CELL_MAJORITY: assert (cout_o == maj3(x_i, y_i, cin_i)); // R6
    end
  end
endmodule

// File: rtl/peres_ripple_adder.sv
module peres_ripple_adder
  import rev_adder_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  input  logic         cin_i,
  input  logic [N-1:0] anc_i,
  output logic [N-1:0] x_o,
  output logic [N-1:0] y_o,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  localparam int unsigned PRIM_COUNT    = PRIMS_PER_CELL * N;
  localparam int unsigned MCT_COUNT     = PRIM_COUNT * PRIM_MCT_EQ;
  localparam int unsigned QUANTUM_COST  = PRIM_COUNT * PRIM_COST;
  localparam int unsigned ANCILLA_LINES = N;

  logic [N:0] carry_line;

  assign carry_line[0] = cin_i;

  for (genvar k = 0; k < N; k++) begin : g_cell
    peres_add_cell u_cell (
      .x_i   (x_i[k]),
      .y_i   (y_i[k]),
      .cin_i (carry_line[k]),
      .anc_i (anc_i[k]),
      .x_o   (x_o[k]),
      .y_o   (y_o[k]),
      .sum_o (sum_o[k]),
      .cout_o(carry_line[k+1])
    );
  end

  assign cout_o = carry_line[N];

  always_comb begin
    AST_ANCILLA_ZERO: assert (anc_i == '0); // R3
    if (anc_i == '0) begin
      AST_ARITH_SUM: assert ({cout_o, sum_o} == ({1'b0, x_i} + {1'b0, y_i} + {{N{1'b0}}, cin_i})); // R3
    end
    AST_OPERAND_PASS: assert ((x_o == x_i) && (y_o == y_i)); // R4
  end
endmodule

// File: tb/peres_ripple_adder_tb.sv
module peres_ripple_adder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int WATCHDOG_CYCLES = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N-1:0] x_i = '0, y_i = '0, anc_i = '0;
  logic         cin_i = 1'b0;
  logic [N-1:0] x_o, y_o, sum_o;
  logic         cout_o;

  logic ga = 1'b0, gb = 1'b0, gc = 1'b0;
  logic gp, gq, gr;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  peres_ripple_adder #(.N(N)) u_dut (
    .x_i(x_i), .y_i(y_i), .cin_i(cin_i), .anc_i(anc_i),
    .x_o(x_o), .y_o(y_o), .sum_o(sum_o), .cout_o(cout_o)
  );

  peres_gate u_gate (
    .a_i(ga), .b_i(gb), .c_i(gc), .p_o(gp), .q_o(gq), .r_o(gr)
  );

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (x=%0d y=%0d cin=%0d)",
               req, actual, expected, x_i, y_i, cin_i);
    end
  endtask

  task automatic apply(input int xv, input int yv, input int cv);
    @(negedge clk);
    x_i = xv[N-1:0]; y_i = yv[N-1:0]; cin_i = cv[0]; anc_i = '0;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG_CYCLES);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit [7:0] seen;
    int carry;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: all-zero inputs give all-zero outputs (R3)
    apply(0, 0, 0);
    check("R3 idle sum", int'({cout_o, sum_o}), 0);

    // R1 / R2: standalone primitive, all 8 patterns
    seen = '0;
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      ga = p[2]; gb = p[1]; gc = p[0];
      @(posedge clk);
      #(CLK_PERIOD/4);
      check("R1 mapping", int'({gp, gq, gr}),
            int'({p[2], p[2] ^ p[1], (p[2] & p[1]) ^ p[0]}));
      seen[{gp, gq, gr}] = 1'b1;
    end
    check("R2 bijective", $countones(seen), 8);

    // R3 / R4 / R5: exhaustive sweep
    for (int xv = 0; xv < (1 << N); xv++) begin
      for (int yv = 0; yv < (1 << N); yv++) begin
        for (int cv = 0; cv < 2; cv++) begin
          apply(xv, yv, cv);
          check("R3 sum", int'({cout_o, sum_o}), xv + yv + cv);
          check("R4 x pass", int'(x_o), xv);
          check("R4 y pass", int'(y_o), yv);
          check("R5 bit0", int'(sum_o[0]), (xv ^ yv ^ cv) & 1);
          carry = cv;
          for (int k = 0; k < N; k++) begin
            check("R5 bitk", int'(sum_o[k]), ((xv >> k) ^ (yv >> k) ^ carry) & 1);
            carry = (((xv >> k) & 1) + ((yv >> k) & 1) + carry) >= 2 ? 1 : 0;
          end
          check("R6 carry", int'(cout_o), carry);
        end
      end
    end

    // R6: full ripple through all positions
    apply((1 << N) - 1, 0, 1);
    check("R6 ripple sum", int'(sum_o), 0);
    check("R6 ripple cout", int'(cout_o), 1);
    apply((1 << N) - 1, (1 << N) - 1, 1);
    check("R6 max sum", int'({cout_o, sum_o}), (1 << (N + 1)) - 1);

    // R7: cost tally constants
    check("R7 prims", int'(u_dut.PRIM_COUNT), 2 * N);
    check("R7 mct", int'(u_dut.MCT_COUNT), 4 * N);
    check("R7 cost", int'(u_dut.QUANTUM_COST), 8 * N);
    check("R7 ancilla", int'(u_dut.ANCILLA_LINES), N);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule